// File: doc/BRIEF.md
# DMA Channel Termination and Interrupt Flag Control

This block holds the control and status bits of one DMA channel: the transfer enable, the interrupt enable, the block-error flag and the interrupt-request flag. It watches strobes from the channel's bus engine and decides when an active transfer stops. Those strobes mark the end of each bus cycle, the last cycle of a block, and the occurrence of an interrupt source such as an exhausted transfer count. It also reacts to a non-maskable interrupt and to entry into standby.

A transfer that has started a block always runs to the end of that block. Only reset, standby entry or a non-maskable interrupt can cut a block short. A non-maskable interrupt that cuts a block short leaves the block-error flag set. When a source ends the transfer, the enable bit drops at the end of the bus cycle that closes the block. The request flag follows one clock later. The channel interrupt line is the request flag gated by the interrupt enable. When software sets the enable again, the request is withdrawn.

A 4-bit register write port updates the bits. In a non-block mode the bus engine holds the block-last strobe high on every cycle, so that each bus cycle counts as a complete unit.

Top module: `dma_chan_ctl`

## Requirements
- R1: After reset all four bits read 0 and the interrupt line is low.
- R2: A write sets the transfer enable from data bit 0 and the interrupt enable from data bit 1. The enable rises at the clock edge that takes the write.
- R3: While a block is in progress, a write of 0 to the enable bit is ignored. A source event does not stop the transfer before the bus cycle that carries the block-last strobe. A block is in progress after a bus-cycle end without block-last, and until a bus-cycle end with block-last.
- R4: A source event while enabled clears the enable at the first bus-cycle end with block-last, at or after the event. The request flag becomes 1 on the following clock edge.
- R5: A non-maskable interrupt during a block clears the enable and sets the block-error flag at the next edge.
- R6: A non-maskable interrupt while enabled but between blocks clears the enable and leaves the block-error flag unchanged.
- R7: The interrupt line is high exactly when the request flag and the interrupt enable are both 1.
- R8: A write of 1 to data bit 0 while the enable is 0 sets the enable and clears the request flag at the same edge.
- R9: Writing 0 to data bit 2 clears the block-error flag, and writing 0 to data bit 3 clears the request flag. Writing 1 to either bit has no effect.
- R10: Standby entry clears the enable and drops any pending source event. It keeps the block-error flag, the request flag and the interrupt enable.
- R11: When a source event and a non-maskable interrupt arrive in the same cycle during a block, the enable clears and the block-error flag sets at the next edge. The request flag sets one edge later.
- R12: Source events while the enable is 0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| standby_i | input | 1 | Standby entry pulse |
| nmi_i | input | 1 | Non-maskable interrupt pulse |
| cyc_end_i | input | 1 | End of a DMA bus cycle |
| blk_last_i | input | 1 | Qualifies cyc_end_i as the last cycle of a block |
| src_evt_i | input | 1 | Interrupt source event |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 4 | Write data: bit0 enable, bit1 irq enable, bit2 error, bit3 request |
| en_o | output | 1 | Transfer enable bit |
| ie_o | output | 1 | Interrupt enable bit |
| berr_o | output | 1 | Block-error flag |
| irqf_o | output | 1 | Interrupt-request flag |
| irq_o | output | 1 | Channel interrupt line |

## Verification
The stop logic is tried with three patterns. In the first, a source event arrives mid-block and the block's last cycle comes later, which shows that the stop is deferred rather than immediate. In the second, a non-maskable interrupt falls mid-block and, separately, between blocks, which tells the error-setting abort apart from the plain stop. In the third, a source event coincides with an abort. Further patterns are software writes of 0 to the enable mid-block, source events while disabled, and standby with a pending source. These show that nothing but reset, standby or a non-maskable interrupt breaks a block, and that the retained flags survive standby.

// File: rtl/dma_chan_ctl_pkg.sv
`timescale 1ns/1ps
package dma_chan_ctl_pkg;
    localparam int unsigned CTRL_W   = 4;
    localparam int unsigned BIT_EN   = 0;
    localparam int unsigned BIT_IE   = 1;
    localparam int unsigned BIT_BERR = 2;
    localparam int unsigned BIT_IRQF = 3;

    typedef struct packed {
        logic en;
        logic in_blk;
        logic src_pend;
        logic irq_pend;
        logic berr;
    } xfer_st_t;

    typedef struct packed {
        logic irqf;
        logic ie;
    } irq_st_t;
endpackage

// File: rtl/dma_xfer_ctl.sv
`timescale 1ns/1ps
module dma_xfer_ctl
    import dma_chan_ctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic standby_i,
    input  logic nmi_i,
    input  logic cyc_end_i,
    input  logic blk_last_i,
    input  logic src_evt_i,
    input  logic wr_en_i,
    input  logic wr_en_bit_i,
    input  logic wr_berr_bit_i,
    input  logic resume_i,
    output logic en_o,
    output logic berr_o,
    output logic stop_pulse_o
);
    xfer_st_t st_d, st_q;
    logic     src_seen;

    always_comb begin
        st_d          = st_q;
        st_d.irq_pend = 1'b0;
        src_seen      = st_q.src_pend | src_evt_i;

        // software writes
        if (wr_en_i) begin
            st_d.berr = st_q.berr & wr_berr_bit_i;
            if (wr_en_bit_i) begin
                st_d.en = 1'b1;
            end else if (!st_q.in_blk) begin
                st_d.en       = 1'b0;
                st_d.src_pend = 1'b0;
            end
        end
        if (resume_i) begin
            st_d.src_pend = 1'b0;
        end

        // normal progress and source-driven stop
        if (st_q.en) begin
            if (src_evt_i) begin
                st_d.src_pend = 1'b1;
            end
            if (cyc_end_i) begin
                st_d.in_blk = !blk_last_i;
                if (blk_last_i && src_seen) begin
                    st_d.en       = 1'b0;
                    st_d.src_pend = 1'b0;
                    st_d.irq_pend = 1'b1;
                end
            end
        end

        // abort by non-maskable interrupt
        if (nmi_i && st_q.en) begin
            st_d.en       = 1'b0;
            st_d.in_blk   = 1'b0;
            st_d.src_pend = 1'b0;
            st_d.irq_pend = src_seen;
            if (st_q.in_blk) begin
                st_d.berr = 1'b1;
            end
        end

        // standby entry
        if (standby_i) begin
            st_d.en       = 1'b0;
            st_d.in_blk   = 1'b0;
            st_d.src_pend = 1'b0;
            st_d.irq_pend = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_o         = st_q.en;
    assign berr_o       = st_q.berr;
    assign stop_pulse_o = st_q.irq_pend;

    // R3
    blk_atomic_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(st_q.en) && $past(st_q.in_blk && !(cyc_end_i && blk_last_i)))
        |-> $past(nmi_i || standby_i));

    // R5
    berr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.berr) |-> $past(nmi_i && st_q.en && st_q.in_blk));

    // R10
    standby_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        standby_i |=> !st_q.en);
endmodule

// File: rtl/dma_irq_flag.sv
`timescale 1ns/1ps
module dma_irq_flag
    import dma_chan_ctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en_i,
    input  logic wr_ie_bit_i,
    input  logic wr_irqf_bit_i,
    input  logic stop_pulse_i,
    input  logic resume_i,
    input  logic en_i,
    output logic irqf_o,
    output logic ie_o,
    output logic irq_o
);
    irq_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en_i) begin
            st_d.ie   = wr_ie_bit_i;
            st_d.irqf = st_q.irqf & wr_irqf_bit_i;
        end
        if (stop_pulse_i) begin
            st_d.irqf = 1'b1;
        end
        if (resume_i) begin
            st_d.irqf = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irqf_o = st_q.irqf;
    assign ie_o   = st_q.ie;
    assign irq_o  = st_q.irqf & st_q.ie;

    // R4
    irqf_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.irqf) |-> !en_i);

    // R8
    resume_withdraw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resume_i |=> !st_q.irqf);
endmodule

// File: rtl/dma_chan_ctl.sv
`timescale 1ns/1ps
module dma_chan_ctl
    import dma_chan_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              standby_i,
    input  logic              nmi_i,
    input  logic              cyc_end_i,
    input  logic              blk_last_i,
    input  logic              src_evt_i,
    input  logic              wr_en_i,
    input  logic [CTRL_W-1:0] wr_data_i,
    output logic              en_o,
    output logic              ie_o,
    output logic              berr_o,
    output logic              irqf_o,
    output logic              irq_o
);
    logic en_w;
    logic stop_pulse_w;
    logic resume_w;

    assign resume_w = wr_en_i & wr_data_i[BIT_EN] & ~en_w;

    dma_xfer_ctl i_xfer (
        .clk          (clk),
        .rst_n        (rst_n),
        .standby_i    (standby_i),
        .nmi_i        (nmi_i),
        .cyc_end_i    (cyc_end_i),
        .blk_last_i   (blk_last_i),
        .src_evt_i    (src_evt_i),
        .wr_en_i      (wr_en_i),
        .wr_en_bit_i  (wr_data_i[BIT_EN]),
        .wr_berr_bit_i(wr_data_i[BIT_BERR]),
        .resume_i     (resume_w),
        .en_o         (en_w),
        .berr_o       (berr_o),
        .stop_pulse_o (stop_pulse_w)
    );

    dma_irq_flag i_irq (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en_i      (wr_en_i),
        .wr_ie_bit_i  (wr_data_i[BIT_IE]),
        .wr_irqf_bit_i(wr_data_i[BIT_IRQF]),
        .stop_pulse_i (stop_pulse_w),
        .resume_i     (resume_w),
        .en_i         (en_w),
        .irqf_o       (irqf_o),
        .ie_o         (ie_o),
        .irq_o        (irq_o)
    );

    assign en_o = en_w;

    // R7
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (ie_o && irqf_o));
endmodule

// File: tb/test_dma_chan_ctl.sv
`timescale 1ns/1ps
module test_dma_chan_ctl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       standby_i = 1'b0, nmi_i = 1'b0, cyc_end_i = 1'b0;
    logic       blk_last_i = 1'b0, src_evt_i = 1'b0, wr_en_i = 1'b0;
    logic [3:0] wr_data_i = 4'h0;
    logic       en_o, ie_o, berr_o, irqf_o, irq_o;

    int unsigned n_tests = 0;
    int unsigned n_fail  = 0;
    bit          done    = 1'b0;

    typedef struct {
        string    tag;
        logic [4:0] v;  // {en, ie, berr, irqf, irq}
    } exp_t;
    exp_t exp_q[$];

    always #4 clk = ~clk;

    dma_chan_ctl i_dma_chan_ctl (
        .clk(clk), .rst_n(rst_n), .standby_i(standby_i), .nmi_i(nmi_i),
        .cyc_end_i(cyc_end_i), .blk_last_i(blk_last_i), .src_evt_i(src_evt_i),
        .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
        .en_o(en_o), .ie_o(ie_o), .berr_o(berr_o), .irqf_o(irqf_o), .irq_o(irq_o)
    );

    // one clock edge, then pulses return low away from the edge
    task automatic step();
        @(posedge clk);
        #1;
        standby_i = 0; nmi_i = 0; cyc_end_i = 0; blk_last_i = 0;
        src_evt_i = 0; wr_en_i = 0; wr_data_i = 4'h0;
    endtask

    task automatic expect_st(string tag, logic en, logic ie, logic berr, logic irqf);
        exp_t e;
        e.tag = tag;
        e.v   = {en, ie, berr, irqf, irqf & ie};
        exp_q.push_back(e);
    endtask

    task automatic wr(logic [3:0] d);
        wr_en_i = 1; wr_data_i = d;
    endtask

    // monitor: compare at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            while (exp_q.size() > 0) begin
                exp_t e;
                logic [4:0] got;
                e   = exp_q.pop_front();
                got = {en_o, ie_o, berr_o, irqf_o, irq_o};
                n_tests++;
                if (got !== e.v) begin
                    n_fail++;
                    $display("FAIL %s: got {en,ie,berr,irqf,irq}=%b expected %b", e.tag, got, e.v);
                end
            end
        end
    end

    initial begin
        #160000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got hang expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 0;
        step(); step(); step();
        rst_n = 1;
        step();
        expect_st("R1 reset state", 0, 0, 0, 0);

        wr(4'b0011); step();
        expect_st("R2 enable and irq enable written", 1, 1, 0, 0);

        cyc_end_i = 1; blk_last_i = 0; step();
        expect_st("R2 block begins", 1, 1, 0, 0);

        wr(4'b0010); step();
        expect_st("R3 write 0 to enable mid-block ignored", 1, 1, 0, 0);

        src_evt_i = 1; cyc_end_i = 1; blk_last_i = 0; step();
        expect_st("R3 source waits for block end", 1, 1, 0, 0);

        cyc_end_i = 1; blk_last_i = 1; step();
        expect_st("R4 enable clears at block end, flag not yet", 0, 1, 0, 0);
        step();
        expect_st("R4 request flag one edge later / R7 line high", 0, 1, 0, 1);

        wr(4'b1000); step();
        expect_st("R7 line low with irq enable 0 / R9 write 1 no effect", 0, 0, 0, 1);

        wr(4'b0011); step();
        expect_st("R8 resume clears request", 1, 1, 0, 0);

        nmi_i = 1; step();
        expect_st("R6 nmi between blocks, no error", 0, 1, 0, 0);

        wr(4'b0011); step();
        cyc_end_i = 1; blk_last_i = 0; step();
        nmi_i = 1; step();
        expect_st("R5 nmi mid-block sets error", 0, 1, 1, 0);

        wr(4'b0110); step();
        expect_st("R9 write 1 to error flag keeps it", 0, 1, 1, 0);
        wr(4'b0010); step();
        expect_st("R9 write 0 clears error flag", 0, 1, 0, 0);

        src_evt_i = 1; cyc_end_i = 1; blk_last_i = 1; step();
        step();
        expect_st("R12 source while disabled ignored", 0, 1, 0, 0);
        wr(4'b0011); step();
        cyc_end_i = 1; blk_last_i = 1; step();
        expect_st("R12 no stale source after enable", 1, 1, 0, 0);

        cyc_end_i = 1; blk_last_i = 0; step();
        src_evt_i = 1; nmi_i = 1; step();
        expect_st("R11 abort wins, error set", 0, 1, 1, 0);
        step();
        expect_st("R11 request flag follows", 0, 1, 1, 1);

        wr(4'b0110); step();
        expect_st("R9 write 0 clears request flag", 0, 1, 1, 0);
        wr(4'b0111); step();
        expect_st("R8 resume keeps error flag", 1, 1, 1, 0);

        src_evt_i = 1; step();
        standby_i = 1; step();
        expect_st("R10 standby clears enable, keeps flags", 0, 1, 1, 0);
        step(); step();
        expect_st("R10 pending source dropped", 0, 1, 1, 0);

        rst_n = 0; step();
        rst_n = 1;
        expect_st("R1 reset clears all", 0, 0, 0, 0);

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule